// File: doc/BRIEF.md
# Single-Density Track Image Sequencer

This block produces, byte by byte, the complete image of one revolution of a single-density, ten-sector floppy track and hands it to a downstream FM encoder. Each revolution opens with a lead-in, then carries ten sectors in ascending order. Every sector has an ID field and a data field, each opened by a flagged address-mark byte and closed by a CRC that the block works out itself. Fixed gaps sit around the fields, and 0xFF filler pads the revolution to an exact byte count. The image then starts again at once.

The current track number is a plain input and goes into every ID field. Sector payload comes from external storage through a read port addressed by sector and byte index. That storage returns data one cycle after the address. The block therefore always presents the address of the byte it will show in the next cycle. Output bytes leave through a valid/ready handshake together with a mark flag and a start-of-revolution strobe.

Top module: `tis_track_seq`

## Requirements
- R1: While reset is applied and for the first cycles after release, `out_valid` is low. The first valid byte after reset is the first byte of a revolution, with `out_sot` high.
- R2: A revolution opens with 16 bytes of 0xFF followed by 6 bytes of 0x00.
- R3: Each ID field is 0xFE with `out_mark` high, then the track input, 0x00, the sector number and 0x01, each with `out_mark` low, then a 2-byte CRC.
- R4: After the ID CRC comes a gap of 0xFF bytes, 11 for sector 0 and 12 for every other sector, then 6 bytes of 0x00.
- R5: Each data field is 0xFB with `out_mark` high, then 256 payload bytes, then a 2-byte CRC, then 12 bytes of 0xFF and 6 bytes of 0x00.
- R6: Each CRC is CRC-16 with polynomial 0x1021 and preset 0xFFFF, taken MSB-first over the mark byte and every following byte of that field. It is sent high byte first.
- R7: Sectors are numbered 0 to 9 and appear in ascending order.
- R8: After sector 9, 0xFF filler makes each revolution exactly 3125 bytes. `out_sot` is high only on the first byte of each revolution, and the next revolution follows with no gap.
- R9: While `out_valid` is high and `out_ready` is low, `out_data`, `out_mark` and `out_sot` hold their values and the sequence does not advance.
- R10: Payload byte i of sector s is the storage word at (`rd_sector`=s, `rd_index`=i), returned one cycle after the address. `out_mark` is high only on the 0xFE and 0xFB mark bytes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| track | input | 8 | Track number placed in every ID field |
| out_data | output | 8 | Current track byte |
| out_mark | output | 1 | Current byte is an address mark |
| out_sot | output | 1 | Current byte is the first of a revolution |
| out_valid | output | 1 | Byte is valid |
| out_ready | input | 1 | Consumer accepts the byte this cycle |
| rd_sector | output | 4 | Storage read sector |
| rd_index | output | 8 | Storage read byte index |
| rd_data | input | 8 | Storage read data, one cycle after the address |

## Verification
On every cycle the assertions check that a stalled byte holds steady, that the mark flag appears only on the two mark values, that the first valid byte after reset is a revolution start, and that revolution starts are exactly 3125 accepted bytes apart. Only the bench's scenarios can show the byte-exact layout of gaps and fields, the sector-0 short gap, the CRC values, the use of the track input and the correct addressing of payload bytes. It does so by comparing whole revolutions, under back-to-back and random stalls, against an image it builds itself.

// File: rtl/tis_pkg.sv
package tis_pkg;

  typedef enum logic [3:0] {
    SEG_LEAD_FF, SEG_LEAD_00, SEG_IDAM, SEG_IDFLD, SEG_IDCRC,
    SEG_GAP_FF, SEG_GAP_00, SEG_DAM, SEG_DATA, SEG_DCRC,
    SEG_TAIL_FF, SEG_TAIL_00, SEG_FILL
  } seg_e;

  localparam logic [7:0]  ID_MARK   = 8'hFE;
  localparam logic [7:0]  DATA_MARK = 8'hFB;
  localparam logic [7:0]  LEN_CODE  = 8'h01;
  localparam logic [15:0] CRC_POLY  = 16'h1021;
  localparam logic [15:0] CRC_SEED  = 16'hFFFF;

  // MSB-first CRC-16 step over one byte
  function automatic logic [15:0] crc_byte(logic [15:0] c, logic [7:0] b);
    logic [15:0] r;
    logic        fb;
    r = c;
    for (int k = 7; k >= 0; k--) begin
      fb = r[15] ^ b[k];
      r  = {r[14:0], 1'b0};
      if (fb) r = r ^ CRC_POLY;
    end
    return r;
  endfunction

endpackage

// File: rtl/tis_seq_ctrl.sv
module tis_seq_ctrl
  import tis_pkg::*;
#(
  parameter int SECTORS      = 10,
  parameter int SECTOR_BYTES = 256,
  parameter int TRACK_BYTES  = 3125,
  parameter int LEAD_FF      = 16,
  parameter int SYNC_00      = 6,
  parameter int GAP_SHORT    = 11,
  parameter int GAP_LONG     = 12,
  parameter int TAIL_FF      = 12,
  parameter int CW           = 12,
  parameter int SW           = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv,
  output seg_e          cur_seg,
  output logic [CW-1:0] cur_cnt,
  output logic [SW-1:0] cur_sec,
  output seg_e          nxt_seg,
  output logic [CW-1:0] nxt_cnt,
  output logic [SW-1:0] nxt_sec
);

  localparam int SEC_LEN  = 1 + 4 + 2 + GAP_LONG + SYNC_00 + 1 + SECTOR_BYTES + 2 + TAIL_FF + SYNC_00;
  localparam int USED     = LEAD_FF + SYNC_00 + SECTORS * SEC_LEN - (GAP_LONG - GAP_SHORT);
  localparam int FILL_LEN = TRACK_BYTES - USED;

  seg_e          seg_q;
  logic [CW-1:0] cnt_q;
  logic [SW-1:0] sec_q;
  logic [CW-1:0] seg_len;
  logic          seg_last;

  always_comb begin
    case (seg_q)
      SEG_LEAD_FF: seg_len = CW'(LEAD_FF);
      SEG_IDFLD:   seg_len = CW'(4);
      SEG_IDCRC,
      SEG_DCRC:    seg_len = CW'(2);
      SEG_GAP_FF:  seg_len = (sec_q == '0) ? CW'(GAP_SHORT) : CW'(GAP_LONG);
      SEG_DATA:    seg_len = CW'(SECTOR_BYTES);
      SEG_TAIL_FF: seg_len = CW'(TAIL_FF);
      SEG_FILL:    seg_len = CW'(FILL_LEN);
      SEG_IDAM,
      SEG_DAM:     seg_len = CW'(1);
      default:     seg_len = CW'(SYNC_00);
    endcase
    seg_last = (cnt_q == seg_len - CW'(1));

    nxt_seg = seg_q;
    nxt_sec = sec_q;
    nxt_cnt = cnt_q + CW'(1);
    if (seg_last) begin
      nxt_cnt = '0;
      case (seg_q)
        SEG_LEAD_FF: nxt_seg = SEG_LEAD_00;
        SEG_LEAD_00: nxt_seg = SEG_IDAM;
        SEG_IDAM:    nxt_seg = SEG_IDFLD;
        SEG_IDFLD:   nxt_seg = SEG_IDCRC;
        SEG_IDCRC:   nxt_seg = SEG_GAP_FF;
        SEG_GAP_FF:  nxt_seg = SEG_GAP_00;
        SEG_GAP_00:  nxt_seg = SEG_DAM;
        SEG_DAM:     nxt_seg = SEG_DATA;
        SEG_DATA:    nxt_seg = SEG_DCRC;
        SEG_DCRC:    nxt_seg = SEG_TAIL_FF;
        SEG_TAIL_FF: nxt_seg = SEG_TAIL_00;
        SEG_TAIL_00: begin
          if (sec_q == SW'(SECTORS - 1)) begin
            nxt_seg = SEG_FILL;
          end else begin
            nxt_seg = SEG_IDAM;
            nxt_sec = sec_q + SW'(1);
          end
        end
        default: begin
          nxt_seg = SEG_LEAD_FF;
          nxt_sec = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seg_q <= SEG_LEAD_FF;
      cnt_q <= '0;
      sec_q <= '0;
    end else if (adv) begin
      seg_q <= nxt_seg;
      cnt_q <= nxt_cnt;
      sec_q <= nxt_sec;
    end
  end

  assign cur_seg = seg_q;
  assign cur_cnt = cnt_q;
  assign cur_sec = sec_q;

endmodule

// File: rtl/tis_crc_acc.sv
module tis_crc_acc
  import tis_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        adv,
  input  seg_e        seg,
  input  logic [7:0]  byte_in,
  output logic [15:0] crc
);

  logic [15:0] crc_q;
  logic [15:0] crc_d;
  logic        crc_en;

  always_comb begin
    crc_en = adv;
    crc_d  = crc_q;
    case (seg)
      SEG_IDAM, SEG_DAM:   crc_d = crc_byte(CRC_SEED, byte_in);
      SEG_IDFLD, SEG_DATA: crc_d = crc_byte(crc_q, byte_in);
      default:             crc_en = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      crc_q <= CRC_SEED;
    else if (crc_en) crc_q <= crc_d;
  end

  assign crc = crc_q;

endmodule

// File: rtl/tis_track_seq.sv
module tis_track_seq
  import tis_pkg::*;
#(
  parameter int SECTORS      = 10,
  parameter int SECTOR_BYTES = 256,
  parameter int TRACK_BYTES  = 3125,
  parameter int LEAD_FF      = 16,
  parameter int SYNC_00      = 6,
  parameter int GAP_SHORT    = 11,
  parameter int GAP_LONG     = 12,
  parameter int TAIL_FF      = 12,
  parameter int SW           = $clog2(SECTORS),
  parameter int IW           = $clog2(SECTOR_BYTES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [7:0]    track,
  output logic [7:0]    out_data,
  output logic          out_mark,
  output logic          out_sot,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [SW-1:0] rd_sector,
  output logic [IW-1:0] rd_index,
  input  logic [7:0]    rd_data
);

  localparam int CW = $clog2(TRACK_BYTES + 1);

  logic [1:0]    rst_sync;
  logic          rst_q_n;
  logic          primed;
  logic          adv;
  seg_e          cur_seg, nxt_seg;
  logic [CW-1:0] cur_cnt, nxt_cnt;
  logic [SW-1:0] cur_sec, nxt_sec;
  logic [15:0]   crc;
  logic [7:0]    byte_c;
  logic          mark_c;

  // reset asserted at once, released on a clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_q_n = rst_sync[1];

  // the first storage word is in place one cycle after reset release
  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) primed <= 1'b0;
    else          primed <= 1'b1;
  end

  assign adv = primed & out_ready;

  tis_seq_ctrl #(
    .SECTORS(SECTORS), .SECTOR_BYTES(SECTOR_BYTES), .TRACK_BYTES(TRACK_BYTES),
    .LEAD_FF(LEAD_FF), .SYNC_00(SYNC_00), .GAP_SHORT(GAP_SHORT),
    .GAP_LONG(GAP_LONG), .TAIL_FF(TAIL_FF), .CW(CW), .SW(SW)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_q_n), .adv(adv),
    .cur_seg(cur_seg), .cur_cnt(cur_cnt), .cur_sec(cur_sec),
    .nxt_seg(nxt_seg), .nxt_cnt(nxt_cnt), .nxt_sec(nxt_sec)
  );

  tis_crc_acc u_crc (
    .clk(clk), .rst_n(rst_q_n), .adv(adv),
    .seg(cur_seg), .byte_in(byte_c), .crc(crc)
  );

  always_comb begin
    mark_c = 1'b0;
    case (cur_seg)
      SEG_IDAM: begin byte_c = ID_MARK;   mark_c = 1'b1; end
      SEG_DAM:  begin byte_c = DATA_MARK; mark_c = 1'b1; end
      SEG_IDFLD: begin
        case (cur_cnt[1:0])
          2'd0:    byte_c = track;
          2'd1:    byte_c = 8'h00;
          2'd2:    byte_c = 8'(cur_sec);
          default: byte_c = LEN_CODE;
        endcase
      end
      SEG_IDCRC, SEG_DCRC: byte_c = cur_cnt[0] ? crc[7:0] : crc[15:8];
      SEG_DATA:  byte_c = rd_data;
      SEG_LEAD_00, SEG_GAP_00, SEG_TAIL_00: byte_c = 8'h00;
      default:   byte_c = 8'hFF;
    endcase
  end

  // address the byte that will be on show next cycle
  assign rd_sector = adv ? nxt_sec : cur_sec;
  assign rd_index  = adv ? nxt_cnt[IW-1:0] : cur_cnt[IW-1:0];

  assign out_data  = byte_c;
  assign out_mark  = mark_c;
  assign out_sot   = (cur_seg == SEG_LEAD_FF) && (cur_cnt == '0);
  assign out_valid = primed;

endmodule

// File: rtl/tis_track_seq_chk.sv
module tis_track_seq_chk #(
  parameter int TRACK_BYTES = 3125
) (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] out_data,
  input logic       out_mark,
  input logic       out_sot,
  input logic       out_valid,
  input logic       out_ready
);

  int   acc_cnt;
  logic seen_sot;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_cnt  <= 0;
      seen_sot <= 1'b0;
    end else if (out_valid && out_ready) begin
      if (out_sot) begin
        acc_cnt  <= 1;
        seen_sot <= 1'b1;
      end else begin
        acc_cnt <= acc_cnt + 1;
      end
    end
  end

  // R9: a stalled byte holds
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_mark) && $stable(out_sot)));

  // R10: mark flag only on the two mark values
  p_mark_value_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_mark) |-> (out_data == 8'hFE || out_data == 8'hFB));

  // R1: first valid byte is a revolution start, valid never drops
  p_first_sot_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> out_sot);

  p_valid_kept_r1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> out_valid);

  // R8: revolution starts are exactly TRACK_BYTES accepted bytes apart
  p_rev_len_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_sot && seen_sot) |-> (acc_cnt == TRACK_BYTES));

  p_no_early_sot_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_sot && seen_sot) |-> (acc_cnt < TRACK_BYTES));

  p_sot_filler_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_sot) |-> (out_data == 8'hFF && !out_mark));

endmodule

bind tis_track_seq tis_track_seq_chk u_chk (
  .clk(clk), .rst_n(rst_q_n), .out_data(out_data), .out_mark(out_mark),
  .out_sot(out_sot), .out_valid(out_valid), .out_ready(out_ready)
);

// File: tb/sim_tis_track_seq.sv
`timescale 1ns/1ps
module sim_tis_track_seq;

  localparam int TRK = 3125;

  logic       clk;
  logic       rst_n;
  logic [7:0] track;
  logic [7:0] out_data;
  logic       out_mark, out_sot, out_valid, out_ready;
  logic [3:0] rd_sector;
  logic [7:0] rd_index;
  logic [7:0] rd_data;

  int total = 0;
  int bad   = 0;
  int bp;
  logic [7:0] salt;

  logic [7:0] exp_b [TRK];
  logic       exp_m [TRK];
  string      exp_t [TRK];

  logic       prev_stall = 1'b0;
  logic [7:0] prev_data;
  logic       prev_mark, prev_sot;

  tis_track_seq u0 (
    .clk(clk), .rst_n(rst_n), .track(track),
    .out_data(out_data), .out_mark(out_mark), .out_sot(out_sot),
    .out_valid(out_valid), .out_ready(out_ready),
    .rd_sector(rd_sector), .rd_index(rd_index), .rd_data(rd_data)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic logic [7:0] mem_val(int s, int i, logic [7:0] k);
    return 8'((s * 53 + i * 7 + int'(k)) ^ (i >> 2));
  endfunction

  // storage model, one-cycle read latency (R10)
  always_ff @(posedge clk) rd_data <= mem_val(int'(rd_sector), int'(rd_index), salt);

  function automatic logic [15:0] crc_ref(logic [15:0] c, logic [7:0] b);
    logic [15:0] r = c;
    for (int k = 7; k >= 0; k--) begin
      if (r[15] ^ b[k]) r = {r[14:0], 1'b0} ^ 16'h1021;
      else              r = {r[14:0], 1'b0};
    end
    return r;
  endfunction

  task automatic put(logic [7:0] v, logic m, string t);
    exp_b[bp] = v; exp_m[bp] = m; exp_t[bp] = t; bp++;
  endtask

  task automatic build(logic [7:0] trk);
    logic [15:0] c;
    logic [7:0]  v;
    bp = 0;
    for (int i = 0; i < 16; i++) put(8'hFF, 1'b0, "R2");
    for (int i = 0; i < 6; i++)  put(8'h00, 1'b0, "R2");
    for (int s = 0; s < 10; s++) begin
      c = crc_ref(16'hFFFF, 8'hFE); put(8'hFE, 1'b1, "R3");
      c = crc_ref(c, trk);   put(trk, 1'b0, "R3");
      c = crc_ref(c, 8'h00); put(8'h00, 1'b0, "R3");
      c = crc_ref(c, 8'(s)); put(8'(s), 1'b0, "R7");
      c = crc_ref(c, 8'h01); put(8'h01, 1'b0, "R3");
      put(c[15:8], 1'b0, "R6"); put(c[7:0], 1'b0, "R6");
      for (int i = 0; i < ((s == 0) ? 11 : 12); i++) put(8'hFF, 1'b0, "R4");
      for (int i = 0; i < 6; i++) put(8'h00, 1'b0, "R4");
      c = crc_ref(16'hFFFF, 8'hFB); put(8'hFB, 1'b1, "R5");
      for (int i = 0; i < 256; i++) begin
        v = mem_val(s, i, salt);
        c = crc_ref(c, v); put(v, 1'b0, "R10");
      end
      put(c[15:8], 1'b0, "R6"); put(c[7:0], 1'b0, "R6");
      for (int i = 0; i < 12; i++) put(8'hFF, 1'b0, "R5");
      for (int i = 0; i < 6; i++)  put(8'h00, 1'b0, "R5");
    end
    while (bp < TRK) put(8'hFF, 1'b0, "R8");
  endtask

  task automatic run_rev(logic [7:0] trk, int pct);
    int   pos = 0;
    logic r;
    track = trk;
    salt  = 8'($urandom);
    build(trk);
    while (pos < TRK) begin
      @(negedge clk);
      if (prev_stall) begin
        total++;
        if (out_data !== prev_data || out_mark !== prev_mark || out_sot !== prev_sot) begin
          bad++;
          $display("FAIL R9 hold act=%h/%b/%b exp=%h/%b/%b", out_data, out_mark, out_sot,
                   prev_data, prev_mark, prev_sot);
        end
      end
      r = (($urandom % 100) < pct);
      out_ready = r;
      if (out_valid && r) begin
        total++;
        if (out_data !== exp_b[pos] || out_mark !== exp_m[pos] || out_sot !== (pos == 0)) begin
          bad++;
          $display("FAIL %s pos=%0d act=%h/m%b/s%b exp=%h/m%b/s%b", exp_t[pos], pos,
                   out_data, out_mark, out_sot, exp_b[pos], exp_m[pos], (pos == 0));
        end
        pos++;
      end
      prev_stall = out_valid && !r;
      prev_data  = out_data;
      prev_mark  = out_mark;
      prev_sot   = out_sot;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired act=running exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd2718));
    rst_n = 1'b0; out_ready = 1'b0; track = 8'h00; salt = 8'h00;
    repeat (4) @(negedge clk);
    total++;
    if (out_valid !== 1'b0) begin
      bad++; $display("FAIL R1 valid in reset act=%b exp=0", out_valid);
    end
    rst_n = 1'b1;
    @(negedge clk);
    total++;
    if (out_valid !== 1'b0) begin
      bad++; $display("FAIL R1 valid after release act=%b exp=0", out_valid);
    end
    run_rev(8'h00, 100);          // back to back, track 0
    run_rev(8'($urandom), 60);    // random stalls
    run_rev(8'hFF, 30);           // heavy stalls, all-ones track
    run_rev(8'($urandom), 85);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule